// File: doc/BRIEF.md
# Table-Driven Quadrature Downconverter

This block moves a real, signed intermediate-frequency sample stream down to complex baseband. A numerically controlled oscillator with a 24-bit phase register adds a tuning word to its phase on every clock. When the register overflows it wraps. The upper ten bits of that phase select one entry of a stored sine table. The cosine comes from the same table at an index a quarter turn ahead. Each incoming sample is multiplied by the cosine to form the in-phase output. It is multiplied by the negated sine to form the quadrature output. Both products are rounded to 16 bits.

The oscillator frequency is the tuning word times the clock rate divided by 2^24. The finest step is therefore one part in 2^24 of the clock rate. The word may change on any clock. The change takes hold in the very next addition, and the accumulated phase carries on from where it was. The sine table is computed as constants when the design elaborates, so no external memory image is needed. A sample and its valid flag appear at the output exactly three clocks after they enter.

Top module: `lut_ddc`

## Requirements
- R1: While reset is low, and on the first clock after it rises, `out_valid`, `out_i` and `out_q` are all zero. The phase register restarts at 0, so the first sample accepted after reset is mixed at phase 0.
- R2: `out_valid` equals `in_valid` from three clocks earlier, and the I/Q pair shown with it belongs to that same sample.
- R3: On every clock with reset high, the phase register adds `tune_word` and wraps modulo 2^24, whether or not `in_valid` is set. A sample is mixed at the phase held before that clock's addition.
- R4: The table index is phase bits [23:14]. Sine entry a is round(2047·sin(2πa/1024)), and the cosine for index a is sine entry (a+256) mod 1024. So index 0 gives cos 2047 and sin 0, index 256 gives 0 and 2047, index 512 gives −2047 and 0, and index 768 gives 0 and −2047.
- R5: `out_i` is floor((x·cos + 512)/1024) in 16-bit two's complement, where x is the 14-bit signed sample.
- R6: `out_q` is floor((−x·sin + 512)/1024), so a positive tuning word moves the spectrum downward.
- R7: A tuning word of 0 after reset holds the phase at 0. Then `out_i` is floor((x·2047+512)/1024) and `out_q` is 0.
- R8: A tuning word of 2^23 after reset alternates the table index between 0 and 512. The sign of the in-phase gain flips on every sample and `out_q` stays 0.
- R9: A new tuning word is used in the addition on the clock where it is first presented, and the phase is not cleared by the change.
- R10: Tuning words of 2^23 and above still accumulate modulo 2^24, which acts as a negative frequency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register samples on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the cycle's sample as meaningful |
| in_sample | input | 14 | Signed IF sample |
| tune_word | input | 24 | Phase increment added each clock |
| out_valid | output | 1 | `in_valid` delayed by three clocks |
| out_i | output | 16 | Rounded in-phase product |
| out_q | output | 16 | Rounded quadrature product (negated sine) |

## Verification
The assertions rely on two things about the inputs: reset is held for at least one clock, and `tune_word` is a defined value on every clock, because the phase check adds the previous word to the previous phase. The bench drives every input from the falling edge and keeps a defined word on the bus for the whole run, including while reset is low and across word changes in the middle of a stream. The three-clock valid check only starts once three clocks have passed since reset, so pipeline contents flushed by a reset are never compared against samples that were presented while reset was low.

// File: rtl/lut_ddc_pkg.sv
// Package lut_ddc_pkg
// Shared elaboration-time helpers for the downconverter. They compute the
// sine table in fixed point using integer arithmetic only.
// Assumes: the table depth is a power of two of at least four entries.
package lut_ddc_pkg;

    localparam int     FRAC_W     = 28;
    localparam longint HALF_PI_FX = 64'sd421657428;   // pi/2 scaled by 2^28

    // Returns sin(pi/2 * k / quarter) as a 2^28-scaled value (Taylor series, 7 terms)
    function automatic longint quarter_sin_fx(input int k, input int quarter);
        longint x;
        longint term;
        longint acc;
        x    = (HALF_PI_FX * longint'(k)) / longint'(quarter);
        term = x;
        acc  = x;
        for (int n = 1; n <= 6; n++) begin
            term = (term * x) >>> FRAC_W;
            term = (term * x) >>> FRAC_W;
            term = -term / longint'((2 * n) * (2 * n + 1));
            acc  = acc + term;
        end
        return acc;
    endfunction

    // Returns the rounded amplitude of sine at table index idx
    function automatic int sine_entry(input int idx, input int addr_w, input int amp_w);
        int     depth;
        int     quarter;
        int     quad;
        int     rem_i;
        int     k;
        longint peak;
        longint mag;
        depth   = 1 << addr_w;
        quarter = depth >> 2;
        quad    = idx / quarter;
        rem_i   = idx % quarter;
        k       = (quad == 1 || quad == 3) ? (quarter - rem_i) : rem_i;
        peak    = (longint'(1) <<< (amp_w - 1)) - 1;
        mag     = (quarter_sin_fx(k, quarter) * peak + (longint'(1) <<< (FRAC_W - 1))) >>> FRAC_W;
        return (quad >= 2) ? -int'(mag) : int'(mag);
    endfunction

endpackage

// File: rtl/ddc_phase_acc.sv
// Module ddc_phase_acc
// Phase register of the oscillator. It adds the tuning word on every clock
// and wraps on overflow, so the frequency is word * Fclk / 2^PHASE_W.
// Assumes: the tuning word is stable around the rising edge.
module ddc_phase_acc #(
    parameter int PHASE_W = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] tune_word,
    output logic [PHASE_W-1:0] phase
);

    // Accumulate the increment; the carry out is dropped (modulo wrap)
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
        end else begin
            phase <= phase + tune_word;
        end
    end

endmodule

// File: rtl/ddc_sincos_rom.sv
// Module ddc_sincos_rom
// Holds one full-cycle sine table, built from constants at elaboration,
// and reads it on two ports in one clock: sine at the index, and cosine at
// the index plus a quarter turn.
// Assumes: ADDR_W >= 2; the read data registers need no reset.
module ddc_sincos_rom #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 12
) (
    input  logic                    clk,
    input  logic [ADDR_W-1:0]       addr,
    output logic signed [AMP_W-1:0] cos_q,
    output logic signed [AMP_W-1:0] sin_q
);

    localparam int DEPTH   = 1 << ADDR_W;
    localparam int QUARTER = DEPTH / 4;

    logic signed [AMP_W-1:0] table_w [DEPTH];
    logic        [ADDR_W-1:0] cos_addr;

    for (genvar a = 0; a < DEPTH; a++) begin : g_entry
        localparam logic signed [AMP_W-1:0] ENTRY =
            AMP_W'(lut_ddc_pkg::sine_entry(a, ADDR_W, AMP_W));
        assign table_w[a] = ENTRY;
    end

    // Cosine index: a quarter turn ahead, wrapping at the table end
    always_comb begin
        cos_addr = addr + ADDR_W'(QUARTER);
    end

    // Registered read of both table ports
    always_ff @(posedge clk) begin
        sin_q <= table_w[addr];
        cos_q <= table_w[cos_addr];
    end

endmodule

// File: rtl/ddc_mixer.sv
// Module ddc_mixer
// Multiplies the sample by cosine (I) and by negated sine (Q). Each product
// is rounded half-up to OUT_W bits and registered, and the valid flag is
// carried alongside.
// Assumes: OUT_W < IN_W + AMP_W and the table peak is below full scale, so
// neither product overflows OUT_W after rounding.
module ddc_mixer #(
    parameter int IN_W  = 14,
    parameter int AMP_W = 12,
    parameter int OUT_W = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    valid_in,
    input  logic signed [IN_W-1:0]  sample,
    input  logic signed [AMP_W-1:0] cos_val,
    input  logic signed [AMP_W-1:0] sin_val,
    output logic                    valid_out,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    localparam int PROD_W = IN_W + AMP_W;
    localparam int PW1    = PROD_W + 1;
    localparam int SHIFT  = PROD_W - OUT_W;
    localparam logic signed [PW1-1:0] ROUND_BIAS = PW1'(1) <<< (SHIFT - 1);

    logic signed [PW1-1:0] prod_i;
    logic signed [PW1-1:0] prod_q;
    logic signed [PW1-1:0] rnd_i;
    logic signed [PW1-1:0] rnd_q;

    // Form both products with a bit of headroom and add the rounding bias
    always_comb begin
        prod_i = PW1'(sample) * PW1'(cos_val);
        prod_q = -(PW1'(sample) * PW1'(sin_val));
        rnd_i  = prod_i + ROUND_BIAS;
        rnd_q  = prod_q + ROUND_BIAS;
    end

    // Register the rounded outputs and the matching valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_out <= 1'b0;
            out_i     <= '0;
            out_q     <= '0;
        end else begin
            valid_out <= valid_in;
            out_i     <= OUT_W'(rnd_i >>> SHIFT);
            out_q     <= OUT_W'(rnd_q >>> SHIFT);
        end
    end

endmodule

// File: rtl/lut_ddc.sv
// Module lut_ddc
// Quadrature downconverter with a table-driven oscillator. The pipeline has
// three registers: stage 1 captures the sample and the table index taken
// from the current phase, stage 2 is the table read, and stage 3 is the
// product register.
// Assumes: one sample per clock at most; in_valid only qualifies the data.
module lut_ddc #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 12,
    parameter int IN_W    = 14,
    parameter int OUT_W   = 16
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic signed [IN_W-1:0]  in_sample,
    input  logic [PHASE_W-1:0]      tune_word,
    output logic                    out_valid,
    output logic signed [OUT_W-1:0] out_i,
    output logic signed [OUT_W-1:0] out_q
);

    logic [PHASE_W-1:0]      phase_q;
    logic [ADDR_W-1:0]       addr_s1;
    logic signed [IN_W-1:0]  sample_s1;
    logic signed [IN_W-1:0]  sample_s2;
    logic                    valid_s1;
    logic                    valid_s2;
    logic signed [AMP_W-1:0] cos_s2;
    logic signed [AMP_W-1:0] sin_s2;

    ddc_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .tune_word (tune_word),
        .phase     (phase_q)
    );

    // Stage 1: take the sample and the truncated phase it is mixed with
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s1  <= 1'b0;
            sample_s1 <= '0;
            addr_s1   <= '0;
        end else begin
            valid_s1  <= in_valid;
            sample_s1 <= in_sample;
            addr_s1   <= phase_q[PHASE_W-1 -: ADDR_W];
        end
    end

    ddc_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
        .clk   (clk),
        .addr  (addr_s1),
        .cos_q (cos_s2),
        .sin_q (sin_s2)
    );

    // Stage 2: keep the sample aligned with the table read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_s2  <= 1'b0;
            sample_s2 <= '0;
        end else begin
            valid_s2  <= valid_s1;
            sample_s2 <= sample_s1;
        end
    end

    ddc_mixer #(.IN_W(IN_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_mix (
        .clk       (clk),
        .rst_n     (rst_n),
        .valid_in  (valid_s2),
        .sample    (sample_s2),
        .cos_val   (cos_s2),
        .sin_val   (sin_s2),
        .valid_out (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

endmodule

// File: rtl/lut_ddc_chk.sv
// Module lut_ddc_chk
// Property checker attached to lut_ddc. It watches the ports together with
// the phase, table and pipeline signals.
// Assumes: tune_word is never unknown while reset is high.
module lut_ddc_chk #(
    parameter int PHASE_W = 24,
    parameter int ADDR_W  = 10,
    parameter int AMP_W   = 12,
    parameter int IN_W    = 14,
    parameter int OUT_W   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    in_valid,
    input logic                    out_valid,
    input logic signed [OUT_W-1:0] out_i,
    input logic signed [OUT_W-1:0] out_q,
    input logic [PHASE_W-1:0]      phase,
    input logic [PHASE_W-1:0]      tune_word,
    input logic [ADDR_W-1:0]       addr_s1,
    input logic signed [AMP_W-1:0] cos_s2,
    input logic signed [AMP_W-1:0] sin_s2,
    input logic signed [IN_W-1:0]  sample_s2
);

    localparam logic signed [AMP_W-1:0] PEAK  = AMP_W'((1 << (AMP_W - 1)) - 1);
    localparam logic [ADDR_W-1:0]       HALF  = ADDR_W'(1 << (ADDR_W - 1));

    logic [1:0] since_rst;

    // Count clocks since reset, saturating at three
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (!out_valid && out_i == '0 && out_q == '0));

    // R2
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    // R3
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (phase == PHASE_W'($past(phase) + $past(tune_word))));

    // R4
    zero_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_s1 == '0) |=> (cos_s2 == PEAK && sin_s2 == '0));

    // R4
    half_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_s1 == HALF) |=> (cos_s2 == -PEAK && sin_s2 == '0));

    // R5
    zero_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_s2 == '0) |=> (out_i == '0 && out_q == '0));

endmodule

bind lut_ddc lut_ddc_chk #(
    .PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .IN_W(IN_W), .OUT_W(OUT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_i     (out_i),
    .out_q     (out_q),
    .phase     (phase_q),
    .tune_word (tune_word),
    .addr_s1   (addr_s1),
    .cos_s2    (cos_s2),
    .sin_s2    (sin_s2),
    .sample_s2 (sample_s2)
);

// File: tb/lut_ddc_bench.sv
// Bench for lut_ddc: an independent phase model and arithmetic expected
// values. Results at the four cardinal table indices are checked exactly;
// all other indices are checked against the ideal real product within the
// error bound of table and output rounding.
module lut_ddc_bench;

    localparam int    PHASE_W = 24;
    localparam int    ADDR_W  = 10;
    localparam int    IN_W    = 14;
    localparam int    OUT_W   = 16;
    localparam real   TWO_PI  = 6.283185307179586;
    localparam longint PH_MASK = (64'sd1 <<< PHASE_W) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_valid = 1'b0;
    logic signed [IN_W-1:0]  in_sample = '0;
    logic [PHASE_W-1:0]      tune_word = '0;
    logic                    out_valid;
    logic signed [OUT_W-1:0] out_i;
    logic signed [OUT_W-1:0] out_q;

    int     checks = 0;
    int     fails  = 0;
    bit     done   = 1'b0;
    string  seg_tag = "R1";
    longint ph_model = 0;
    int     e_v [1:3];
    int     e_x [1:3];
    int     e_a [1:3];
    int     lcg = 12345;

    lut_ddc u_lut_ddc (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sample (in_sample),
        .tune_word (tune_word),
        .out_valid (out_valid),
        .out_i     (out_i),
        .out_q     (out_q)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input real expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d expected=%0.3f", tag, act, expv);
        end
    endtask

    // Reference pipeline: records sample, valid and table index per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            ph_model = 0;
            for (int k = 1; k <= 3; k++) begin
                e_v[k] = 0; e_x[k] = 0; e_a[k] = 0;
            end
        end else begin
            e_v[3] = e_v[2]; e_x[3] = e_x[2]; e_a[3] = e_a[2];
            e_v[2] = e_v[1]; e_x[2] = e_x[1]; e_a[2] = e_a[1];
            e_v[1] = int'(in_valid);
            e_x[1] = int'(in_sample);
            e_a[1] = int'(ph_model >>> (PHASE_W - ADDR_W));
            ph_model = (ph_model + longint'(tune_word)) & PH_MASK;
        end
    end

    // Compare outputs with the reference away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == e_v[3][0], "R2 valid", longint'(out_valid), real'(e_v[3]));
            if (e_v[3] != 0) begin
                longint x;
                int     a;
                x = longint'(e_x[3]);
                a = e_a[3];
                if (a % 256 == 0) begin
                    longint c;
                    longint s;
                    longint ei;
                    longint eq;
                    c  = (a == 0) ? 2047 : (a == 512) ? -2047 : 0;
                    s  = (a == 256) ? 2047 : (a == 768) ? -2047 : 0;
                    ei = (x * c + 512) >>> 10;
                    eq = (-(x * s) + 512) >>> 10;
                    chk(longint'(out_i) == ei, {"R4,R5,", seg_tag, " I"}, longint'(out_i), real'(ei));
                    chk(longint'(out_q) == eq, {"R4,R6,", seg_tag, " Q"}, longint'(out_q), real'(eq));
                end else begin
                    real th;
                    real ri;
                    real rq;
                    real tol;
                    real di;
                    real dq;
                    th  = TWO_PI * real'(a) / 1024.0;
                    ri  = real'(x) * 2047.0 * $cos(th) / 1024.0;
                    rq  = -real'(x) * 2047.0 * $sin(th) / 1024.0;
                    tol = ((x < 0) ? -real'(x) : real'(x)) / 2048.0 + 0.51;
                    di  = real'(out_i) - ri;
                    dq  = real'(out_q) - rq;
                    chk((di <= tol) && (di >= -tol), {"R5,", seg_tag, " I"}, longint'(out_i), ri);
                    chk((dq <= tol) && (dq >= -tol), {"R6,", seg_tag, " Q"}, longint'(out_q), rq);
                end
            end
        end
    end

    function automatic logic signed [IN_W-1:0] gen_sample(input int pat, input int i);
        if (pat == 0) return (i % 2 == 0) ? -14'sd8192 : 14'sd8191;
        if (pat == 1) return IN_W'(i * 37 - 4000);
        lcg = lcg * 1103515245 + 12345;
        return IN_W'(lcg >>> 9);
    endfunction

    task automatic run_seg(input string tag, input logic [PHASE_W-1:0] tw, input int n, input int pat);
        seg_tag = tag;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tune_word = tw;
            in_valid  = (pat == 2) ? (i % 5 != 3) : 1'b1;
            in_sample = gen_sample(pat, i);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n    = 1'b0;
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0.0);
        chk(out_i == '0, "R1 out_i", longint'(out_i), 0.0);
        chk(out_q == '0, "R1 out_q", longint'(out_q), 0.0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0.0);
        chk(out_i == '0, "R1 out_i", longint'(out_i), 0.0);
        chk(out_q == '0, "R1 out_q", longint'(out_q), 0.0);
        rst_n = 1'b1;
        run_seg("R7", 24'd0, 60, 1);
        do_reset();
        run_seg("R8", 24'h800000, 60, 0);
        do_reset();
        run_seg("R1", 24'h400000, 60, 2);
        run_seg("R3", 24'h123457, 600, 2);
        run_seg("R10", 24'hF3A001, 400, 2);
        run_seg("R9", 24'h0ABCDE, 100, 1);
        run_seg("R9", 24'h300000, 100, 2);
        run_seg("R2", 24'h000100, 8, 2);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (6) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(5.0 * 20000.0);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL R2 watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule